// File: doc/BRIEF.md
# Triggered Fractional Clock Divider

This block derives a clock-enable pulse train from its parent clock through a phase-accumulator divider whose divisor carries a configurable number of fractional bits. A small register bus configures it. The divisor field stores the divisor minus one in fixed point. A parent-select field sits in the same register and is passed out as a plain code.

All configuration registers are protected. Writes are accepted only after an access register has been opened with a key. A new divisor and select code sit in a staging register and have no effect until software sets a commit trigger. That trigger bit reads back as one while the change is pending. It clears by itself once the block has waited a fixed number of parent cycles and the divider has produced its next output pulse. The new settings, and a fresh accumulator phase, apply from the cycle after that pulse.

The divider only advances while its output gate input is high. A pending commit therefore needs the output running in order to complete.

Top module: `frac_clk_div`

## Requirements
- R1: After reset, access is locked, the config and trigger registers read 0, `src_sel_o` is 0, and the divisor is 1.0, so `clk_en_o` is high on every cycle while `gate_en` is high.
- R2: The access register is at offset 0 and is written as one word. The access state changes only when bits 31:8 equal 0x00A5A5 and bits 7:1 are zero; bit 0 = 1 opens access and bit 0 = 0 closes it. Any other word leaves the state unchanged. Reading offset 0 returns the state in bit 0.
- R3: While access is closed, writes to offset 1 (config) and offset 2 (trigger) change nothing.
- R4: The config register is at offset 1. The divisor field is in bits FIELD_W-1:0 and the select code is in bits 17:16. A write replaces both fields, and a read returns them with every other bit reading 0.
- R5: Writing the config register alone changes neither the pulse rate nor `src_sel_o`.
- R6: Writing 1 to bit 0 of offset 2 starts a commit, and the bit reads as 1 until the commit completes. The commit completes at the first `clk_en_o` pulse that occurs at least SETTLE_CYC cycles after the pending cycle in which the count started. With a current divisor of 1.0, the bit therefore reads 1 for exactly SETTLE_CYC+1 cycles.
- R7: From the first cycle in which the trigger reads 0, the staged field f and the staged select code are active, and the accumulator starts from zero. Over N cycles, `clk_en_o` is then high floor(N·2^FRAC_W/(f+2^FRAC_W)) times, and `src_sel_o` equals the select code.
- R8: The all-ones field gives the largest divisor, (2^FIELD_W−1)+2^FRAC_W in fixed point.
- R9: While `gate_en` is low, `clk_en_o` stays low, the accumulator holds its value, and a pending commit stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gate_en | input | 1 | Output gate; the divider advances only while this is high |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | 2 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| clk_en_o | output | 1 | Divided clock-enable pulse |
| src_sel_o | output | SEL_W | Active parent-select code |

## Verification
The assertions assume that a write strobe lasts one cycle and carries a stable offset. They also assume that `gate_en` only changes between register operations, so that a commit and its gate state are related in a simple way. The bench drives every write as a one-cycle strobe set up on the falling edge. It changes the gate only while no bus access is in flight. It sweeps every divisor field of a 6-bit, 2-fractional-bit configuration and computes the pulse count for each one arithmetically.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam logic [23:0] ACCESS_KEY = 24'h00A5A5;

  typedef enum logic [1:0] {
    OFF_ACCESS = 2'd0,
    OFF_CONFIG = 2'd1,
    OFF_TRIG   = 2'd2,
    OFF_SPARE  = 2'd3
  } reg_off_e;
endpackage

// File: rtl/fcd_regs.sv
module fcd_regs
  import fcd_pkg::*;
#(
  parameter int FIELD_W = 6,
  parameter int SEL_LSB = 16,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         addr,
  input  logic [31:0]        wdata,
  input  logic               trig_busy,
  output logic [31:0]        rdata,
  output logic               unlocked,
  output logic [FIELD_W-1:0] stage_div,
  output logic [SEL_W-1:0]   stage_sel,
  output logic               trig_req
);
  localparam logic [31:0] DIV_MASK = (32'd1 << FIELD_W) - 32'd1;
  localparam logic [31:0] SEL_MASK = ((32'd1 << SEL_W) - 32'd1) << SEL_LSB;
  localparam logic [31:0] CFG_MASK = DIV_MASK | SEL_MASK;

  logic        unlocked_q, unlocked_d;
  logic [31:0] cfg_q, cfg_d;
  logic        key_ok, acc_we, cfg_we;

  // next state
  always_comb begin
    key_ok     = (wdata[31:8] == ACCESS_KEY) && (wdata[7:1] == 7'd0);
    acc_we     = wr_en && (addr == OFF_ACCESS) && key_ok;
    cfg_we     = wr_en && (addr == OFF_CONFIG) && unlocked_q;
    trig_req   = wr_en && (addr == OFF_TRIG) && unlocked_q && wdata[0] && !trig_busy;
    unlocked_d = acc_we ? wdata[0] : unlocked_q;
    cfg_d      = cfg_we ? (wdata & CFG_MASK) : cfg_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      cfg_q      <= 32'd0;
    end else begin
      unlocked_q <= unlocked_d;
      cfg_q      <= cfg_d;
    end
  end

  // read mux
  always_comb begin
    case (addr)
      OFF_ACCESS: rdata = {31'd0, unlocked_q};
      OFF_CONFIG: rdata = cfg_q;
      OFF_TRIG:   rdata = {31'd0, trig_busy};
      default:    rdata = 32'd0;
    endcase
  end

  assign unlocked  = unlocked_q;
  assign stage_div = cfg_q[FIELD_W-1:0];
  assign stage_sel = cfg_q[SEL_LSB +: SEL_W];
endmodule

// File: rtl/fcd_commit.sv
module fcd_commit #(
  parameter int FIELD_W    = 6,
  parameter int SEL_W      = 2,
  parameter int SETTLE_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_req,
  input  logic               tick,
  input  logic [FIELD_W-1:0] stage_div,
  input  logic [SEL_W-1:0]   stage_sel,
  output logic               busy,
  output logic               apply,
  output logic [FIELD_W-1:0] act_div,
  output logic [SEL_W-1:0]   act_sel
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SETTLE_CYC);

  logic               busy_q, busy_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FIELD_W-1:0] div_q, div_d;
  logic [SEL_W-1:0]   sel_q, sel_d;
  logic               settled;

  always_comb begin
    settled = (cnt_q == CNT_END);
    apply   = busy_q && settled && tick;
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    div_d   = div_q;
    sel_d   = sel_q;
    if (trig_req) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (apply) begin
      busy_d = 1'b0;
      div_d  = stage_div;
      sel_d  = stage_sel;
    end else if (busy_q && !settled) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      div_q  <= '0;
      sel_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      div_q  <= div_d;
      sel_q  <= sel_d;
    end
  end

  assign busy    = busy_q;
  assign act_div = div_q;
  assign act_sel = sel_q;
endmodule

// File: rtl/fcd_accum.sv
module fcd_accum #(
  parameter int FIELD_W = 6,
  parameter int FRAC_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gate_en,
  input  logic               restart,
  input  logic [FIELD_W-1:0] act_div,
  output logic               tick
);
  localparam int DIV_W = FIELD_W + 1;
  localparam int SUM_W = DIV_W + 1;
  localparam logic [DIV_W-1:0] STEP_D = DIV_W'(1) << FRAC_W;
  localparam logic [SUM_W-1:0] STEP_S = SUM_W'(1) << FRAC_W;

  logic [DIV_W-1:0] acc_q, acc_d;
  logic [DIV_W-1:0] scaled;
  logic [SUM_W-1:0] sum, wrapped;
  logic             hit;

  always_comb begin
    scaled  = {1'b0, act_div} + STEP_D;
    sum     = {1'b0, acc_q} + STEP_S;
    hit     = sum >= {1'b0, scaled};
    wrapped = sum - {1'b0, scaled};
    tick    = gate_en && hit;
    if (!gate_en)     acc_d = acc_q;
    else if (restart) acc_d = '0;
    else if (hit)     acc_d = wrapped[DIV_W-1:0];
    else              acc_d = sum[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int FIELD_W    = 6,
  parameter int FRAC_W     = 2,
  parameter int SEL_LSB    = 16,
  parameter int SEL_W      = 2,
  parameter int SETTLE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_en,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             clk_en_o,
  output logic [SEL_W-1:0] src_sel_o
);
  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic               unlocked, trig_req, trig_busy, apply;
  logic [FIELD_W-1:0] stage_div, act_div;
  logic [SEL_W-1:0]   stage_sel, act_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  fcd_regs #(.FIELD_W(FIELD_W), .SEL_LSB(SEL_LSB), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .trig_busy(trig_busy), .rdata(rdata), .unlocked(unlocked),
    .stage_div(stage_div), .stage_sel(stage_sel), .trig_req(trig_req)
  );

  fcd_commit #(.FIELD_W(FIELD_W), .SEL_W(SEL_W), .SETTLE_CYC(SETTLE_CYC)) u_commit (
    .clk(clk), .rst_n(rst_sync_n), .trig_req(trig_req), .tick(clk_en_o),
    .stage_div(stage_div), .stage_sel(stage_sel), .busy(trig_busy),
    .apply(apply), .act_div(act_div), .act_sel(act_sel)
  );

  fcd_accum #(.FIELD_W(FIELD_W), .FRAC_W(FRAC_W)) u_accum (
    .clk(clk), .rst_n(rst_sync_n), .gate_en(gate_en), .restart(apply),
    .act_div(act_div), .tick(clk_en_o)
  );

  assign src_sel_o = act_sel;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int FIELD_W    = 6,
  parameter int SEL_W      = 2,
  parameter int SETTLE_CYC = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [1:0]         addr,
  input logic               unlocked,
  input logic               gate_en,
  input logic               busy,
  input logic               tick,
  input logic [FIELD_W-1:0] stage_div,
  input logic [SEL_W-1:0]   stage_sel,
  input logic [FIELD_W-1:0] act_div,
  input logic [SEL_W-1:0]   act_sel
);
  localparam int CW = $clog2(SETTLE_CYC + 2) + 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] pend_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         pend_cnt <= '0;
    else if (!busy)                     pend_cnt <= '0;
    else if (pend_cnt != CMAX)          pend_cnt <= pend_cnt + 1'b1;
  end

  a_r3_locked_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && wr_en && addr == 2'd1) |=> ($stable(stage_div) && $stable(stage_sel)));

  a_r3_locked_trig_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !busy && wr_en && addr == 2'd2) |=> !busy);

  a_r5_idle_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(act_div) && $stable(act_sel)));

  a_r6_apply_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick));

  a_r6_min_settle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(pend_cnt) >= CW'(SETTLE_CYC)));

  a_r9_gate_holds_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !gate_en) |=> busy);
endmodule

bind frac_clk_div fcd_checker #(.FIELD_W(FIELD_W), .SEL_W(SEL_W), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .unlocked(unlocked),
  .gate_en(gate_en), .busy(trig_busy), .tick(clk_en_o), .stage_div(stage_div),
  .stage_sel(stage_sel), .act_div(act_div), .act_sel(act_sel)
);

// File: tb/tb_frac_clk_div.sv
module tb_frac_clk_div;
  localparam int FIELD_W = 6;
  localparam int FRAC_W  = 2;
  localparam int SEL_W   = 2;
  localparam int SETTLE  = 4;
  localparam int STEP    = 1 << FRAC_W;
  localparam int FMAX    = (1 << FIELD_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n, gate_en, wr_en;
  logic [1:0]       addr;
  logic [31:0]      wdata, rdata;
  logic             clk_en_o;
  logic [SEL_W-1:0] src_sel_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  frac_clk_div #(.FIELD_W(FIELD_W), .FRAC_W(FRAC_W), .SEL_LSB(16), .SEL_W(SEL_W),
                 .SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .clk_en_o(clk_en_o), .src_sel_o(src_sel_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic commit(input int f, input int s, output int busy_cyc, output int first);
    wr(2'd1, (32'(s) << 16) | 32'(f));
    wr(2'd2, 32'd1);
    busy_cyc = 0;
    addr = 2'd2;
    #1;
    while (rdata[0]) begin
      busy_cyc++;
      @(negedge clk);
      #1;
    end
    first = clk_en_o ? 1 : 0;
  endtask

  task automatic measure(input int n, input int first, output int cnt);
    cnt = first;
    for (int k = 1; k < n; k++) begin
      @(negedge clk);
      #1;
      if (clk_en_o) cnt++;
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    int bc, fp, cnt, d, n, e;
    rst_n = 1'b0; gate_en = 1'b1; wr_en = 1'b0; addr = 2'd0; wdata = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(2'd0, v); chk(v == 0, "R1 access", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 config", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 trigger", v, 0);
    chk(src_sel_o == 0, "R1 select", src_sel_o, 0);
    measure(10, clk_en_o ? 1 : 0, cnt); chk(cnt == 10, "R1 divide by one", cnt, 10);

    // R3: locked writes dropped
    wr(2'd1, 32'h0001_0005);
    rd(2'd1, v); chk(v == 0, "R3 locked config", v, 0);
    wr(2'd2, 32'd1);
    rd(2'd2, v); chk(v == 0, "R3 locked trigger", v, 0);

    // R2: key handling
    wr(2'd0, 32'h00A5_A601); rd(2'd0, v); chk(v == 0, "R2 wrong key", v, 0);
    wr(2'd0, 32'h00A5_A503); rd(2'd0, v); chk(v == 0, "R2 reserved bits", v, 0);
    wr(2'd0, 32'h00A5_A501); rd(2'd0, v); chk(v == 1, "R2 open", v, 1);

    // R4: field layout
    wr(2'd1, 32'hF002_FFEA);
    rd(2'd1, v); chk(v == 32'h0002_002A, "R4 readback", v, 32'h0002_002A);

    // R5: staged value has no effect yet
    measure(12, clk_en_o ? 1 : 0, cnt); chk(cnt == 12, "R5 rate unchanged", cnt, 12);
    chk(src_sel_o == 0, "R5 select unchanged", src_sel_o, 0);

    // R6: exact latency with divisor 1.0, R7 new rate
    commit(42, 2, bc, fp);
    chk(bc == SETTLE + 1, "R6 pending cycles", bc, SETTLE + 1);
    chk(src_sel_o == 2, "R7 select applied", src_sel_o, 2);
    measure(46, fp, cnt); chk(cnt == 4, "R7 field 42", cnt, 4);

    // R9: gate low stalls output and commit
    @(negedge clk); gate_en = 1'b0;
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd1);
    cnt = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); #1;
      if (clk_en_o) cnt++;
    end
    chk(cnt == 0, "R9 no pulses", cnt, 0);
    rd(2'd2, v); chk(v == 1, "R9 still pending", v, 1);
    gate_en = 1'b1;
    addr = 2'd2; #1;
    while (rdata[0]) begin @(negedge clk); #1; end
    measure(10, clk_en_o ? 1 : 0, cnt); chk(cnt == 10, "R9 resumes", cnt, 10);

    // R7/R8: sweep every field
    for (int f = 0; f <= FMAX; f++) begin
      commit(f, f % 4, bc, fp);
      d = f + STEP;
      n = d + (f % 5);
      e = (n * STEP) / d;
      measure(n, fp, cnt);
      if (f == FMAX) chk(cnt == e, "R8 largest divisor", cnt, e);
      else           chk(cnt == e, "R7 sweep rate", cnt, e);
      chk(src_sel_o == SEL_W'(f % 4), "R7 sweep select", src_sel_o, f % 4);
    end

    // R2 close, then R3
    wr(2'd0, 32'h00A5_A500); rd(2'd0, v); chk(v == 0, "R2 close", v, 0);
    wr(2'd1, 32'h0000_0001);
    rd(2'd1, v); chk(v == {14'd0, 2'd3, 10'd0, 6'd63}, "R3 relocked config", v, 32'h0003_003F);

    done = 1'b1;
    finish_run();
  end
endmodule